// File: doc/BRIEF.md
# Four-outcome compare flag unit

The block compares two 64-bit register values and reports the outcome as a 4-bit N/Z/C/V flag word. The encoding is not the usual subtract-style one. Equal sets Z. Less sets N. Greater sets N and V. Unordered clears every flag. C is never set. A second output gives the same outcome in the conventional subtract-style flag encoding, so the two words can be cross-checked or handed to a consumer that expects ordinary flags.

A type selector picks one of four operand views:

| `cmp_kind` | View | Bits compared |
|---|---|---|
| 0 | single-precision float | upper half, bits 63:32 |
| 1 | double-precision float | all 64 bits |
| 2 | 32-bit integer | lower half, bits 31:0 |
| 3 | 64-bit integer | all 64 bits |

For the integer views, the `unsigned_mode` bit chooses at compare time whether the values are signed or unsigned. Signed is the default, selected when the bit is 0.

Requests enter on a valid/ready handshake, and results leave on a second valid/ready handshake.
- A request is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- The result appears on the next cycle, with `out_valid` acting as the done strobe.
- When the consumer holds `out_ready` low, the result stays put and `in_ready` drops, so no new request is taken until the slot drains.
- A request can be accepted in the same cycle as the previous result is consumed.

Top module: `cmp_flag_unit`

## Requirements
- R1: When the selected operands are equal, `flags_custom` (N,Z,C,V in bits 3..0) is 4'b0100.
- R2: When A is less than B, `flags_custom` is 4'b1000.
- R3: When A is greater than B, `flags_custom` is 4'b1001. Bit 1 (C) of `flags_custom` is never 1.
- R4: For a float view with either operand a NaN (exponent all ones, fraction nonzero), `flags_custom` is 4'b0000.
- R5: `flags_std` (NZCV) encodes the same outcome: equal 4'b0110, less 4'b1000, greater 4'b0010, unordered 4'b0011.
- R6: For the integer views, `unsigned_mode`=0 compares as two's-complement signed and `unsigned_mode`=1 compares as unsigned.
- R7: The single-precision view compares bits 63:32 only. Bits 31:0 of either operand do not affect the result.
- R8: The 32-bit integer view compares bits 31:0 only. Bits 63:32 do not affect the result.
- R9: In the float views, +0 and -0 compare equal, and denormals are ordered by their true value.
- R10: An integer compare never yields the unordered result, even for bit patterns that would be NaN as floats.
- R11: After reset `out_valid` is 0. A request accepted on one edge gives `out_valid`=1 with its flags after the next edge.
- R12: While `out_valid`=1 and `out_ready`=0, the flags and `out_valid` hold and `in_ready` is 0. Requests offered then are not taken and do not change the held flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| cmp_kind | input | 2 | 0 single float, 1 double float, 2 int32, 3 int64 |
| unsigned_mode | input | 1 | 1 = unsigned integer compare, 0 = signed |
| out_valid | output | 1 | Result valid (done strobe) |
| out_ready | input | 1 | Consumer takes result |
| flags_custom | output | 4 | Four-outcome flag word, NZCV |
| flags_std | output | 4 | Conventional flag word, NZCV |

## Verification
Two functions can fall in the same cycle: handing over a held result and accepting a new request. The bench provokes this by stalling the consumer with `out_ready` low while it offers a different request. It then checks that the held flags do not move and that `in_ready` stays low. After that it releases the stall and confirms the slot drains.

Flag correctness is judged against expected outcomes that bench functions compute. The float views are evaluated as real numbers and the integer views as signed or unsigned integers. The random operands are biased toward the following:
- equal pairs
- NaNs
- signed zeros
- sign-flipped twins
- garbage in the ignored half

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  typedef enum logic [1:0] {
    KIND_SP  = 2'd0,
    KIND_DP  = 2'd1,
    KIND_I32 = 2'd2,
    KIND_I64 = 2'd3
  } cmp_kind_e;

  typedef enum logic [1:0] {
    RES_EQ = 2'd0,
    RES_LT = 2'd1,
    RES_GT = 2'd2,
    RES_UN = 2'd3
  } cmp_res_e;

  // four-outcome encoding, NZCV
  localparam logic [3:0] CF_EQ = 4'b0100;
  localparam logic [3:0] CF_LT = 4'b1000;
  localparam logic [3:0] CF_GT = 4'b1001;
  localparam logic [3:0] CF_UN = 4'b0000;

  // conventional subtract-style encoding, NZCV
  localparam logic [3:0] SF_EQ = 4'b0110;
  localparam logic [3:0] SF_LT = 4'b1000;
  localparam logic [3:0] SF_GT = 4'b0010;
  localparam logic [3:0] SF_UN = 4'b0011;

endpackage

// File: rtl/cmp_fp_core.sv
module cmp_fp_core
  import cmp_flag_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_res_e     res
);

  logic a_sign, b_sign;
  logic a_nan, b_nan;
  logic both_zero;
  logic mag_lt, mag_eq;

  assign a_sign    = a[W-1];
  assign b_sign    = b[W-1];
  assign a_nan     = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign b_nan     = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
  assign both_zero = ~|{a[W-2:0], b[W-2:0]};

  // magnitude order equals value order for same-sign encodings, denormals included
  assign mag_lt = a[W-2:0] < b[W-2:0];
  assign mag_eq = a[W-2:0] == b[W-2:0];

  always_comb begin
    if (a_nan || b_nan) begin
      res = RES_UN;
    end else if (both_zero) begin
      res = RES_EQ;
    end else if (a_sign != b_sign) begin
      res = a_sign ? RES_LT : RES_GT;
    end else if (mag_eq) begin
      res = RES_EQ;
    end else if (mag_lt ^ a_sign) begin
      res = RES_LT;
    end else begin
      res = RES_GT;
    end
  end

endmodule

// File: rtl/cmp_int_core.sv
module cmp_int_core
  import cmp_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_signed,
  output cmp_res_e     res
);

  logic signed [W:0] ax, bx;

  // one extra bit: sign-extended when signed, zero-extended when unsigned
  assign ax = {use_signed & a[W-1], a};
  assign bx = {use_signed & b[W-1], b};

  always_comb begin
    if (ax == bx)      res = RES_EQ;
    else if (ax < bx)  res = RES_LT;
    else               res = RES_GT;
  end

endmodule

// File: rtl/cmp_flag_encode.sv
module cmp_flag_encode
  import cmp_flag_pkg::*;
(
  input  cmp_res_e   res,
  output logic [3:0] custom,
  output logic [3:0] std
);

  always_comb begin
    unique case (res)
      RES_EQ:  begin custom = CF_EQ; std = SF_EQ; end
      RES_LT:  begin custom = CF_LT; std = SF_LT; end
      RES_GT:  begin custom = CF_GT; std = SF_GT; end
      default: begin custom = CF_UN; std = SF_UN; end
    endcase
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
#(
  parameter int SP_EXP_W = 8,
  parameter int SP_MAN_W = 23,
  parameter int DP_EXP_W = 11,
  parameter int DP_MAN_W = 52,
  localparam int SP_W   = 1 + SP_EXP_W + SP_MAN_W,
  localparam int DATA_W = 1 + DP_EXP_W + DP_MAN_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        cmp_kind,
  input  logic              unsigned_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        flags_custom,
  output logic [3:0]        flags_std
);

  cmp_res_e res_sp, res_dp, res_i32, res_i64, res_sel;
  logic [3:0] enc_custom, enc_std;
  logic [1:0] kind_q;
  logic take;

  // single view lives in the upper half of the register
  cmp_fp_core #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_fp_sp (
    .a(op_a[DATA_W-1 -: SP_W]), .b(op_b[DATA_W-1 -: SP_W]), .res(res_sp)
  );

  cmp_fp_core #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_fp_dp (
    .a(op_a), .b(op_b), .res(res_dp)
  );

  // integer widths: half register and full register
  cmp_int_core #(.W(HALF_W)) u_int_half (
    .a(op_a[HALF_W-1:0]), .b(op_b[HALF_W-1:0]),
    .use_signed(!unsigned_mode), .res(res_i32)
  );

  cmp_int_core #(.W(DATA_W)) u_int_full (
    .a(op_a), .b(op_b), .use_signed(!unsigned_mode), .res(res_i64)
  );

  always_comb begin
    unique case (cmp_kind)
      KIND_SP:  res_sel = res_sp;
      KIND_DP:  res_sel = res_dp;
      KIND_I32: res_sel = res_i32;
      default:  res_sel = res_i64;
    endcase
  end

  cmp_flag_encode u_enc (
    .res(res_sel), .custom(enc_custom), .std(enc_std)
  );

  // single-entry result slot: refills in the same cycle it drains
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      flags_custom <= 4'b0000;
      flags_std    <= 4'b0000;
      kind_q       <= 2'd0;
    end else if (take) begin
      out_valid    <= 1'b1;
      flags_custom <= enc_custom;
      flags_std    <= enc_std;
      kind_q       <= cmp_kind;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R11: an accepted request is reported on the next cycle
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R12: a stalled result holds still
  a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(flags_custom) && $stable(flags_std)));

  // R3: the carry flag is never set in the custom word
  a_r3_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flags_custom[1]);

  // R5: both output words describe the same outcome
  a_r5_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flags_custom == CF_EQ && flags_std == SF_EQ) ||
                   (flags_custom == CF_LT && flags_std == SF_LT) ||
                   (flags_custom == CF_GT && flags_std == SF_GT) ||
                   (flags_custom == CF_UN && flags_std == SF_UN)));

  // R10: integer views never report unordered
  a_r10_int_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && kind_q[1]) |-> (flags_custom != CF_UN));

endmodule

// File: tb/cmp_flag_unit_bench.sv
`timescale 1ns/1ps
module cmp_flag_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  cmp_kind = 2'd0;
  logic        unsigned_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  flags_custom;
  logic [3:0]  flags_std;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmp_flag_unit u_cmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .cmp_kind(cmp_kind), .unsigned_mode(unsigned_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .flags_custom(flags_custom), .flags_std(flags_std)
  );

  // outcome codes: 0 equal, 1 less, 2 greater, 3 unordered
  function automatic logic [3:0] custom_of(int r);
    case (r)
      0: return 4'b0100;
      1: return 4'b1000;
      2: return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] std_of(int r);
    case (r)
      0: return 4'b0110;
      1: return 4'b1000;
      2: return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic string tag_of(int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic real sp_value(logic [31:0] x);
    real m;
    int  e;
    e = int'(x[30:23]);
    m = real'(x[22:0]);
    if (e == 255) sp_value = 1.0e300;
    else if (e == 0) sp_value = m * (2.0 ** (-149));
    else sp_value = (m + 8388608.0) * (2.0 ** (e - 150));
    if (x[31]) sp_value = -sp_value;
  endfunction

  function automatic int order_real(real x, real y);
    if (x == y) return 0;
    if (x < y) return 1;
    return 2;
  endfunction

  function automatic int expect_res(logic [63:0] a, logic [63:0] b, logic [1:0] k, logic u);
    case (k)
      2'd0: begin
        if ((&a[62:55] && |a[54:32]) || (&b[62:55] && |b[54:32])) return 3;
        return order_real(sp_value(a[63:32]), sp_value(b[63:32]));
      end
      2'd1: begin
        if ((&a[62:52] && |a[51:0]) || (&b[62:52] && |b[51:0])) return 3;
        return order_real($bitstoreal(a), $bitstoreal(b));
      end
      2'd2: begin
        if (a[31:0] == b[31:0]) return 0;
        if (u) return (a[31:0] < b[31:0]) ? 1 : 2;
        return ($signed(a[31:0]) < $signed(b[31:0])) ? 1 : 2;
      end
      default: begin
        if (a == b) return 0;
        if (u) return (a < b) ? 1 : 2;
        return ($signed(a) < $signed(b)) ? 1 : 2;
      end
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request with a free-running consumer; results sampled at the negedge
  task automatic run_cmp(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] k, input logic u, input string tag);
    int r;
    @(negedge clk);
    op_a = a; op_b = b; cmp_kind = k; unsigned_mode = u; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = expect_res(a, b, k, u);
    chk(out_valid == 1'b1, {tag, "/R11 out_valid"}, 64'(out_valid), 64'd1);
    chk(flags_custom == custom_of(r), {tag, "/", tag_of(r), " custom"}, 64'(flags_custom), 64'(custom_of(r)));
    chk(flags_std == std_of(r), {tag, "/R5 std"}, 64'(flags_std), 64'(std_of(r)));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R11 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // directed corner cases
    run_cmp({32'h80000000, 32'h1234}, {32'h00000000, 32'h9999}, 2'd0, 1'b0, "R9 sp -0 vs +0");
    run_cmp(64'h8000000000000000, 64'h0, 2'd1, 1'b0, "R9 dp -0 vs +0");
    run_cmp({32'h00000001, 32'h0}, {32'h00000002, 32'h0}, 2'd0, 1'b0, "R9 sp denorm order");
    run_cmp({32'h3f800000, 32'hFFFFFFFF}, {32'h3f800000, 32'h00000000}, 2'd0, 1'b0, "R7 sp low half ignored");
    run_cmp({32'h7fc00000, 32'h0}, {32'h3f800000, 32'h0}, 2'd0, 1'b0, "R4 sp nan");
    run_cmp(64'h3ff0000000000000, 64'h7ff0000000000001, 2'd1, 1'b0, "R4 dp nan");
    run_cmp({32'h00000000, 32'hFFFFFFFF}, {32'h00000000, 32'h00000001}, 2'd2, 1'b0, "R6 i32 signed");
    run_cmp({32'h00000000, 32'hFFFFFFFF}, {32'h00000000, 32'h00000001}, 2'd2, 1'b1, "R6 i32 unsigned");
    run_cmp({32'hDEADBEEF, 32'h00000005}, {32'h00000000, 32'h00000005}, 2'd2, 1'b0, "R8 i32 high half ignored");
    run_cmp(64'hFFFFFFFFFFFFFFFF, 64'h1, 2'd3, 1'b1, "R6 i64 unsigned");
    run_cmp(64'h7ff8000000000000, 64'h7ff8000000000000, 2'd3, 1'b0, "R10 i64 nan bits");
    run_cmp(64'h7ff8000000000000, 64'h0, 2'd3, 1'b0, "R10 i64 nan vs 0");

    // R12: stalled consumer, competing request offered
    @(negedge clk);
    out_ready = 1'b0;
    op_a = 64'd1; op_b = 64'd2; cmp_kind = 2'd3; unsigned_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R12 stall valid", 64'(out_valid), 64'd1);
    chk(flags_custom == 4'b1000, "R12 stall first result", 64'(flags_custom), 64'h8);
    op_a = 64'd9; op_b = 64'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R12 in_ready low", 64'(in_ready), 64'd0);
      chk(out_valid == 1'b1, "R12 valid held", 64'(out_valid), 64'd1);
      chk(flags_custom == 4'b1000, "R12 custom held", 64'(flags_custom), 64'h8);
      chk(flags_std == 4'b1000, "R12 std held", 64'(flags_std), 64'h8);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 drained", 64'(out_valid), 64'd0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a, b;
      logic [1:0] k;
      logic u;
      int sel;
      a = rnd64(); b = rnd64();
      k = 2'($urandom_range(0, 3));
      u = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 7);
      case (sel)
        0: b = a;
        1: begin
          if (k == 2'd0) begin a[62:55] = 8'hFF; a[54] = 1'b1; end
          else begin a[62:52] = 11'h7FF; a[51] = 1'b1; end
        end
        2: begin
          a = {a[63], 63'd0}; b = {b[63], 63'd0};
          if (k == 2'd0) begin a[31:0] = $urandom(); b = {b[63], 31'd0, 32'h0}; end
        end
        3: b = {~a[63], a[62:0]};
        4: begin b[63:32] = a[63:32]; end
        5: begin b[31:0] = a[31:0]; end
        default: ;
      endcase
      run_cmp(a, b, k, u, "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule